// File: doc/BRIEF.md
# Programmable Supply-Level Detect Controller

This block is the digital side of a supply-level detector that raises an interrupt when the supply crosses a chosen threshold. Software sets the detector up through a 16-bit control word. It chooses the trip level, which way the crossing must go, and whether the detector pauses while the device is idle. The block then drives the analog side: one-hot tap selects for a 15-tap divider, a select for an external threshold input, a divider power enable and a comparator power enable. It gets back two comparator results and a band-gap ready indication, and treats all three as asynchronous.

When the detector is enabled, a counter first waits out a fixed reference settling time. Until that time has passed, no event can be flagged. After that, a comparator result that matches the selected direction sets a sticky flag. Software clears the flag with a pulse. The flag is raised again at once if the condition still holds. The flag drives an interrupt output, gated by an enable input, and also drives a wake request while the device sleeps.

Top module: `supply_detect_ctrl`

## Requirements
- R1: After the asynchronous reset, the control word reads 0000h. The flag, interrupt, wake, tap selects, external select and both analog enables are all 0.
- R2: Control word fields are: bit 15 enable, bit 13 stop-in-idle, bit 7 direction, bits 3:0 level code. These fields take the written value on the edge where the write strobe is high. Bit 6 (band-gap ready) and bit 5 (reference ready) are status bits and cannot be written. Bits 14, 12:8 and 4 always read 0.
- R3: Once the detector becomes active, bit 5 reads 1 exactly STAB_TICKS clock edges after the edge that activated it. The flag never rises unless bit 5 read 1 in the cycle before.
- R4: Bit 6 follows the band-gap ready input while the detector is active. It lags by three edges: two synchroniser stages plus one register.
- R5: With direction 1, the flag is set by the at-or-above comparator input. With direction 0, it is set by the at-or-below input. The other input has no effect. Latency from input to flag is three edges.
- R6: A clear pulse in a cycle where the detect condition still holds leaves the flag at 1.
- R7: While the detector is active, level codes 0 to 14 drive a one-hot tap select at that bit position and assert the divider enable. Code 15 drives no tap, deasserts the divider enable and asserts the external select. While inactive, all of these outputs are 0.
- R8: With stop-in-idle at 1 and the idle input high, the detector is inactive. Bits 6 and 5 read 0, the comparator enable is 0 and no flag is set, and reference settling restarts afterwards. With stop-in-idle at 0, the idle input has no effect.
- R9: The interrupt output is the flag ANDed with the interrupt-enable input. The wake output is the flag ANDed with the sleep input.
- R10: In the cycle after enable is written to 0, bits 6 and 5 read 0. Re-enabling requires a full new settling time.
- R11: The flag stays at 1 until a clear pulse arrives while no detect condition holds. Disabling the detector does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read value |
| flag_clr_i | input | 1 | Flag clear pulse |
| cmp_hi_i | input | 1 | Comparator: sensed level at or above trip (async) |
| cmp_lo_i | input | 1 | Comparator: sensed level at or below trip (async) |
| bg_ok_i | input | 1 | Band-gap ready from analog (async) |
| idle_i | input | 1 | Device in idle mode |
| sleep_i | input | 1 | Device in sleep mode |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-from-sleep request |
| tap_sel_o | output | 15 | One-hot divider tap select |
| ext_sel_o | output | 1 | Route external threshold input to comparator |
| div_en_o | output | 1 | Divider power enable |
| cmp_en_o | output | 1 | Comparator and reference power enable |

## Verification
Directed sequences cover the following:
- A comparator held asserted across enable. This separates the last tick of settling from the first tick where a flag is allowed.
- Each direction driven with only its own input and then with only the opposite input. This shows that the wrong input is ignored.
- A clear pulse issued with the condition still present and again with it gone. This separates hardware re-set from a sticky flag.
- Idle asserted with stop-in-idle on and then off.

Constrained random phases toggle writes, comparator inputs, idle, sleep and clears at random. Every cycle is compared against a bench model of the requirements. This exercises all level codes and direction changes under a running detector.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned N_CODES  = 1 << LVL_W;
  localparam int unsigned N_TAPS   = N_CODES - 1;
  localparam int unsigned B_EN     = 15;
  localparam int unsigned B_SIDL   = 13;
  localparam int unsigned B_DIR    = 7;
  localparam int unsigned B_BG     = 6;
  localparam int unsigned B_REF    = 5;

  typedef struct packed {
    logic             en;
    logic             sidl;
    logic             dir;
    logic [LVL_W-1:0] lvl;
  } ctrl_t;

  typedef struct packed {
    logic bg;
    logic lo;
    logic hi;
  } ana_t;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
  parameter int unsigned STAB_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic ready_o
);
  localparam int unsigned CW = (STAB_TICKS < 2) ? 1 : $clog2(STAB_TICKS);
  localparam logic [CW-1:0] LAST = CW'(STAB_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // gated so that deactivation shows in the same cycle
  assign ready_o = rdy_q & active_i;
endmodule

// File: rtl/sdc_tap_decode.sv
module sdc_tap_decode
  import sdc_pkg::*;
(
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              active_i,
  output logic [N_TAPS-1:0] tap_sel_o,
  output logic              ext_sel_o,
  output logic              div_en_o
);
  logic is_ext;
  assign is_ext = (lvl_i == LVL_W'(N_CODES - 1));

  for (genvar t = 0; t < int'(N_TAPS); t++) begin : g_tap
    assign tap_sel_o[t] = active_i & (lvl_i == LVL_W'(t));
  end

  assign ext_sel_o = active_i & is_ext;
  assign div_en_o  = active_i & ~is_ext;
endmodule

// File: rtl/sdc_flag.sv
module sdc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic detect_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (detect_i) flag_q <= 1'b1;   // set wins over clear
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/supply_detect_ctrl.sv
module supply_detect_ctrl
  import sdc_pkg::*;
#(
  parameter int unsigned STAB_TICKS = 1000,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  input  logic              flag_clr_i,
  input  logic              cmp_hi_i,
  input  logic              cmp_lo_i,
  input  logic              bg_ok_i,
  input  logic              idle_i,
  input  logic              sleep_i,
  input  logic              irq_en_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic [N_TAPS-1:0] tap_sel_o,
  output logic              ext_sel_o,
  output logic              div_en_o,
  output logic              cmp_en_o
);
  ctrl_t ctrl_q;
  ana_t  ana_raw, ana_s;
  logic  active, ref_rdy, bg_q, detect;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (reg_wr_i) begin
      ctrl_q.en   <= reg_wdata_i[B_EN];
      ctrl_q.sidl <= reg_wdata_i[B_SIDL];
      ctrl_q.dir  <= reg_wdata_i[B_DIR];
      ctrl_q.lvl  <= reg_wdata_i[LVL_W-1:0];
    end
  end

  assign active = ctrl_q.en & ~(ctrl_q.sidl & idle_i);

  assign ana_raw = '{bg: bg_ok_i, lo: cmp_lo_i, hi: cmp_hi_i};

  sdc_sync #(.W($bits(ana_t)), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ana_raw),
    .q_o   (ana_s)
  );

  sdc_ref_timer #(.STAB_TICKS(STAB_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .ready_o (ref_rdy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bg_q <= 1'b0;
    else         bg_q <= active & ana_s.bg;
  end

  assign detect = ref_rdy & (ctrl_q.dir ? ana_s.hi : ana_s.lo);

  sdc_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .detect_i(detect),
    .clr_i   (flag_clr_i),
    .flag_o  (flag_o)
  );

  sdc_tap_decode u_taps (
    .lvl_i    (ctrl_q.lvl),
    .active_i (active),
    .tap_sel_o(tap_sel_o),
    .ext_sel_o(ext_sel_o),
    .div_en_o (div_en_o)
  );

  always_comb begin
    reg_rdata_o              = '0;
    reg_rdata_o[B_EN]        = ctrl_q.en;
    reg_rdata_o[B_SIDL]      = ctrl_q.sidl;
    reg_rdata_o[B_DIR]       = ctrl_q.dir;
    reg_rdata_o[B_BG]        = bg_q & active;
    reg_rdata_o[B_REF]       = ref_rdy;
    reg_rdata_o[LVL_W-1:0]   = ctrl_q.lvl;
  end

  assign cmp_en_o = active;
  assign irq_o    = flag_o & irq_en_i;
  assign wake_o   = flag_o & sleep_i;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] reg_rdata_o,
  input logic        flag_clr_i,
  input logic        sleep_i,
  input logic        flag_o,
  input logic        irq_o,
  input logic        wake_o,
  input logic [14:0] tap_sel_o,
  input logic        ext_sel_o
);
  p_ref_gates_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(reg_rdata_o[5]));

  p_ref_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[5]) |-> reg_rdata_o[15]);

  p_unimpl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[14] == 1'b0) && (reg_rdata_o[12:8] == 5'd0) && (reg_rdata_o[4] == 1'b0));

  p_tap_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tap_sel_o) && !(ext_sel_o && (tap_sel_o != '0)));

  p_wake_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (flag_o && sleep_i));

  p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  p_disabled_not_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[15] |-> (reg_rdata_o[6:5] == 2'b00));

  p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
endmodule

bind supply_detect_ctrl sdc_checker u_sdc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_rdata_o(reg_rdata_o),
  .flag_clr_i (flag_clr_i),
  .sleep_i    (sleep_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .tap_sel_o  (tap_sel_o),
  .ext_sel_o  (ext_sel_o)
);

// File: tb/tb_supply_detect_ctrl.sv
`timescale 1ns/1ps
module tb_supply_detect_ctrl;
  localparam int N = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        flag_clr_i = 1'b0, cmp_hi_i = 1'b0, cmp_lo_i = 1'b0, bg_ok_i = 1'b0;
  logic        idle_i = 1'b0, sleep_i = 1'b0, irq_en_i = 1'b0;
  logic        flag_o, irq_o, wake_o, ext_sel_o, div_en_o, cmp_en_o;
  logic [14:0] tap_sel_o;

  int    n_chk = 0, n_bad = 0;
  bit    cmp_on = 1'b0, done = 1'b0;
  string cur_tag = "";

  always #2 clk_i = ~clk_i;

  supply_detect_ctrl #(.STAB_TICKS(N)) dut (.*);

  // ---------------- requirement model ----------------
  logic       m_en, m_sidl, m_dir, m_ok, m_bg, m_flag;
  logic [3:0] m_lvl;
  int         m_cnt;
  logic       hi1, hi2, lo1, lo2, bg1, bg2;

  function automatic logic m_act();
    return m_en && !(m_sidl && idle_i);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_en, m_sidl, m_dir, m_ok, m_bg, m_flag} = '0;
      m_lvl = '0; m_cnt = 0;
      {hi1, hi2, lo1, lo2, bg1, bg2} = '0;
    end else begin
      logic act, det;
      act = m_act();
      det = m_ok && act && (m_dir ? hi2 : lo2);
      m_flag = det || (m_flag && !flag_clr_i);
      if (!act) begin m_cnt = 0; m_ok = 1'b0; end
      else if (!m_ok) begin
        if (m_cnt == N-1) m_ok = 1'b1; else m_cnt++;
      end
      m_bg = act && bg2;
      hi2 = hi1; hi1 = cmp_hi_i;
      lo2 = lo1; lo1 = cmp_lo_i;
      bg2 = bg1; bg1 = bg_ok_i;
      if (reg_wr_i) begin
        m_en = reg_wdata_i[15]; m_sidl = reg_wdata_i[13];
        m_dir = reg_wdata_i[7]; m_lvl = reg_wdata_i[3:0];
      end
    end
  end

  function automatic logic [15:0] exp_rdata();
    logic [15:0] r;
    r = '0;
    r[15] = m_en; r[13] = m_sidl; r[7] = m_dir;
    r[6] = m_bg && m_act(); r[5] = m_ok && m_act(); r[3:0] = m_lvl;
    return r;
  endfunction

  function automatic logic [14:0] exp_taps();
    return (m_act() && m_lvl != 4'hF) ? (15'd1 << m_lvl) : 15'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && cmp_on && !done) begin
      chk(cur_tag, 32'(reg_rdata_o), 32'(exp_rdata()), "rdata");
      chk(cur_tag, 32'({flag_o, irq_o, wake_o}),
          32'({m_flag, m_flag && irq_en_i, m_flag && sleep_i}), "flag/irq/wake");
      chk(cur_tag, 32'({tap_sel_o, ext_sel_o, div_en_o, cmp_en_o}),
          32'({exp_taps(), m_act() && m_lvl == 4'hF, m_act() && m_lvl != 4'hF, m_act()}),
          "taps/ext/div/cmp");
    end
  end

  task automatic wr(logic [15:0] d);
    @(negedge clk_i); reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk_i); flag_clr_i = 1'b1;
    @(negedge clk_i); flag_clr_i = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_n(3);
    // R1 reset state
    chk("R1", 32'(reg_rdata_o), 0, "rdata");
    chk("R1", 32'({flag_o, irq_o, wake_o, tap_sel_o, ext_sel_o, div_en_o, cmp_en_o}), 0, "outputs");
    rst_ni = 1'b1;
    cmp_on = 1'b1;

    // R2 layout, R7 external code
    cur_tag = "R2";
    wr(16'hFFFF);
    chk("R2", 32'(reg_rdata_o), 32'h0000_A08F, "readback");
    chk("R7", 32'({tap_sel_o, ext_sel_o, div_en_o}), 32'b10, "ext code");
    wr(16'h0000);
    chk("R2", 32'(reg_rdata_o), 0, "cleared");

    // R3 settling, R5 direction 0, R7 tap
    cur_tag = "R3";
    cmp_lo_i = 1'b1;
    wait_n(4);
    wr(16'h8003);
    repeat (N-1) @(posedge clk_i);
    #1;
    chk("R3", 32'({reg_rdata_o[5], flag_o}), 0, "before settle");
    @(posedge clk_i); #1;
    chk("R3", 32'({reg_rdata_o[5], flag_o}), 32'b10, "settled, no flag yet");
    @(posedge clk_i); #1;
    chk("R5", 32'(flag_o), 1, "dir0 flag");
    chk("R7", 32'({tap_sel_o, div_en_o}), 32'({15'd1 << 3, 1'b1}), "tap 3");

    // R6 re-set while condition holds; R11 sticky
    cur_tag = "R6";
    clr_pulse();
    chk("R6", 32'(flag_o), 1, "clear with condition");
    cmp_lo_i = 1'b0;
    wait_n(4);
    chk("R11", 32'(flag_o), 1, "sticky");
    clr_pulse();
    chk("R11", 32'(flag_o), 0, "cleared");
    wait_n(2);
    chk("R11", 32'(flag_o), 0, "stays clear");

    // R9 irq / wake
    cur_tag = "R9";
    irq_en_i = 1'b1; sleep_i = 1'b1;
    @(negedge clk_i);
    chk("R9", 32'({irq_o, wake_o}), 0, "no flag");
    cmp_lo_i = 1'b1;
    wait_n(4);
    chk("R9", 32'({flag_o, irq_o, wake_o}), 32'b111, "flag irq wake");
    sleep_i = 1'b0; #1;
    chk("R9", 32'(wake_o), 0, "awake");
    irq_en_i = 1'b0; #1;
    chk("R9", 32'(irq_o), 0, "irq masked");

    // R5 direction 1
    cur_tag = "R5";
    cmp_lo_i = 1'b0;
    wait_n(3);
    clr_pulse();
    wr(16'h8085);
    cmp_lo_i = 1'b1;
    wait_n(5);
    chk("R5", 32'(flag_o), 0, "dir1 ignores lo");
    cmp_lo_i = 1'b0; cmp_hi_i = 1'b1;
    wait_n(2);
    chk("R5", 32'(flag_o), 0, "latency");
    wait_n(1);
    chk("R5", 32'(flag_o), 1, "dir1 flag");
    chk("R7", 32'(tap_sel_o), 32'(15'd1 << 5), "tap 5");

    // R8 stop in idle
    cur_tag = "R8";
    cmp_hi_i = 1'b0;
    wait_n(3);
    clr_pulse();
    wr(16'hA085);
    idle_i = 1'b1; #1;
    chk("R8", 32'({reg_rdata_o[6:5], cmp_en_o, tap_sel_o}), 0, "stopped");
    cmp_hi_i = 1'b1;
    wait_n(6);
    chk("R8", 32'(flag_o), 0, "no flag in idle");
    idle_i = 1'b0;
    wait_n(N);
    chk("R8", 32'(flag_o), 0, "resettling");
    wait_n(2);
    chk("R8", 32'(flag_o), 1, "flag after resume");
    wr(16'h8085);
    idle_i = 1'b1; #1;
    chk("R8", 32'({reg_rdata_o[5], cmp_en_o}), 32'b11, "idle ignored");
    idle_i = 1'b0;

    // R4 band-gap status
    cur_tag = "R4";
    bg_ok_i = 1'b1;
    wait_n(2);
    chk("R4", 32'(reg_rdata_o[6]), 0, "bg latency");
    wait_n(1);
    chk("R4", 32'(reg_rdata_o[6]), 1, "bg ready");

    // R10 disable drops status; R11 flag survives disable
    cur_tag = "R10";
    wr(16'h0085);
    chk("R10", 32'(reg_rdata_o), 32'h0085, "disabled");
    chk("R11", 32'(flag_o), 1, "flag kept");
    wr(16'h8085);
    wait_n(N-1);
    chk("R10", 32'(reg_rdata_o[5]), 0, "resettle");
    wait_n(1);
    chk("R10", 32'(reg_rdata_o[5]), 1, "resettled");

    // random phase
    cur_tag = "RND R2 R5 R7 R9";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk_i);
      reg_wr_i   = ($urandom % 24) == 0;
      reg_wdata_i = 16'($urandom);
      if (($urandom % 3) == 0) reg_wdata_i[15] = 1'b1;
      flag_clr_i = ($urandom % 6) == 0;
      if (($urandom % 5) == 0) cmp_hi_i = ~cmp_hi_i;
      if (($urandom % 5) == 0) cmp_lo_i = ~cmp_lo_i;
      if (($urandom % 9) == 0) bg_ok_i = ~bg_ok_i;
      if (($urandom % 40) == 0) idle_i = ~idle_i;
      if (($urandom % 7) == 0) sleep_i = ~sleep_i;
      if (($urandom % 7) == 0) irq_en_i = ~irq_en_i;
    end
    @(negedge clk_i);
    reg_wr_i = 1'b0; flag_clr_i = 1'b0;
    wait_n(2);
    summary();
  end
endmodule